// File: doc/BRIEF.md
# Masked Packed Float-to-Unsigned Conversion Unit

The unit converts up to sixteen 32-bit single-precision floating-point lanes of a 512-bit source vector into unsigned 32-bit integers in one pass. A vector-length code sets how many of the low lanes take part (4, 8 or 16). Every bit above that length is cleared in the result. Inside the active length, a 16-bit lane mask picks which lanes convert. When masking is enabled, each lane whose mask bit is clear either keeps the matching lane of an old destination vector (merge) or becomes zero (zero mode).

Two source styles exist. For a register-style source, an embedded rounding code replaces the global rounding code, but only when the vector length is 512 bits and the embedded-rounding enable is set. For a memory-style source, the broadcast flag makes every active lane convert the lowest source element. Per-lane invalid and inexact conditions are ORed over the active lanes only and reported next to the result.

Results, flags and a valid strobe are registered. They appear one clock after a request is presented with `in_valid`, and they hold until the next request.

Top module: `pcvt_unit`

## Requirements
- R1: Each converted lane holds its 32-bit float input rounded to an integer under the selected mode, with codes 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. Lane j sits at bits [32j+31:32j].
- R2: A lane whose input is NaN or infinite, or whose rounded value is negative or above 4294967295, yields 32'hFFFFFFFF and raises the invalid flag.
- R3: The precision flag is raised when an active lane's conversion is inexact and that lane is not invalid. An invalid lane never sets the precision flag.
- R4: A lane inside the vector length is active when its mask bit is 1 or when `mask_en` is 0.
- R5: An inactive lane inside the vector length takes the old destination lane when `zero_mode` is 0, and takes 0 when `zero_mode` is 1.
- R6: `vlen` 2'b00 gives 4 lanes, 2'b01 gives 8 lanes, and 2'b10 or 2'b11 gives 16 lanes. All result bits above the active length are 0.
- R7: The embedded code `emb_rc` sets the rounding mode only when the length is 16 lanes, `emb_rnd_en` is 1 and `mem_src` is 0. In every other case `glb_rc` sets it.
- R8: When `mem_src` and `bcast` are both 1, every active lane converts source bits [31:0]. `bcast` has no effect when `mem_src` is 0.
- R9: `flag_invalid` and `flag_precision` are ORs over active lanes only. Inactive lanes and lanes above the length contribute nothing.
- R10: `out_valid`, `result` and both flags reset to 0. A request with `in_valid` high is reflected on the outputs at the next clock edge. Without a request, the outputs hold their values and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | 512 | Source float lanes |
| old_dst | input | 512 | Previous destination, used for merging |
| mask | input | 16 | Per-lane mask |
| mask_en | input | 1 | Masking enable |
| zero_mode | input | 1 | 1 zeroes inactive lanes, 0 merges them |
| bcast | input | 1 | Broadcast lowest element (memory-style source only) |
| mem_src | input | 1 | Source is memory-style |
| vlen | input | 2 | Vector length code |
| emb_rc | input | 2 | Embedded rounding code |
| glb_rc | input | 2 | Global rounding code |
| emb_rnd_en | input | 1 | Embedded rounding enable |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Converted vector |
| flag_invalid | output | 1 | Any active lane invalid |
| flag_precision | output | 1 | Any active lane inexact |

## Verification
The hardest case to reach from the ports is a rounding edge inside a lane whose result is also shaped by the surrounding controls. Examples are an exact tie or a slightly negative value that becomes invalid only under one mode, where that mode comes from the embedded code and the lane is possibly masked off or broadcast. The stimulus sweeps hand-picked boundary encodings (ties, values just below 2^32, 2^32 itself, denormals, negative fractions, NaN, infinities) and pseudo-random encodings through all four modes. It then reruns such vectors under every mask pattern class, every length code, both source styles and conflicting embedded and global codes. The bench compares each lane against a real-number model.

// File: rtl/pcvt_pkg.sv
package pcvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic [31:0] val;
    logic        inv;
    logic        inx;
  } cvt_res_t;

  // Number of active lanes for a length code.
  function automatic int unsigned lanes_for(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      default: return 16;
    endcase
  endfunction

  // Single-precision to unsigned 32-bit conversion with rounding.
  function automatic cvt_res_t f32_to_u32(input logic [31:0] f, input rmode_e rm);
    cvt_res_t    r;
    logic        sgn;
    logic [7:0]  ex;
    logic [22:0] fr;
    logic [23:0] sig;
    logic [25:0] sx;
    logic [25:0] lowmask;
    logic [31:0] ip;
    logic [32:0] mag;
    logic        half;
    logic        stk;
    logic        inc;
    int          eff;
    int          rsh;
    sgn  = f[31];
    ex   = f[30:23];
    fr   = f[22:0];
    r    = '0;
    ip   = '0;
    half = 1'b0;
    stk  = 1'b0;
    inc  = 1'b0;
    sig  = (ex == 8'd0) ? {1'b0, fr} : {1'b1, fr};
    sx   = {2'b00, sig};
    eff  = (ex == 8'd0) ? 1 : int'(ex);
    rsh  = 0;
    lowmask = '0;
    mag  = '0;
    if (ex == 8'hFF) begin
      r.val = 32'hFFFF_FFFF;
      r.inv = 1'b1;
    end else if (ex == 8'd0 && fr == 23'd0) begin
      r.val = 32'd0;
    end else if (eff >= 159) begin
      r.val = 32'hFFFF_FFFF;
      r.inv = 1'b1;
    end else begin
      if (eff >= 150) begin
        ip = 32'(sig) << (eff - 150);
      end else begin
        rsh = 150 - eff;
        if (rsh > 25) begin
          stk = 1'b1;
        end else begin
          ip      = 32'(sx >> rsh);
          half    = sx[rsh-1];
          lowmask = (26'd1 << (rsh - 1)) - 26'd1;
          stk     = |(sx & lowmask);
        end
      end
      case (rm)
        RM_NEAR: inc = half & (stk | ip[0]);
        RM_DOWN: inc = sgn & (half | stk);
        RM_UP:   inc = ~sgn & (half | stk);
        default: inc = 1'b0;
      endcase
      mag = {1'b0, ip} + {32'd0, inc};
      if (sgn ? (mag != 33'd0) : mag[32]) begin
        r.val = 32'hFFFF_FFFF;
        r.inv = 1'b1;
      end else begin
        r.val = sgn ? 32'd0 : mag[31:0];
        r.inx = half | stk;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pcvt_rnd_sel.sv
module pcvt_rnd_sel
  import pcvt_pkg::*;
(
  input  logic [1:0] vlen,
  input  logic       emb_rnd_en,
  input  logic       mem_src,
  input  logic [1:0] emb_rc,
  input  logic [1:0] glb_rc,
  output rmode_e     rm,
  output logic       emb_taken
);
  logic full_len;

  assign full_len  = (lanes_for(vlen) == 16);
  assign emb_taken = full_len & emb_rnd_en & ~mem_src;
  assign rm        = emb_taken ? rmode_e'(emb_rc) : rmode_e'(glb_rc);

  // R7: the embedded code is never picked for a memory-style source
  always_comb begin
    if (mem_src) begin
      a_emb_reg_only_r7: assert (!emb_taken);
    end
  end
endmodule

// File: rtl/pcvt_cvt_lane.sv
module pcvt_cvt_lane
  import pcvt_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] fin,
  input  rmode_e        rm,
  output logic [EW-1:0] uout,
  output logic          inv,
  output logic          inx
);
  cvt_res_t res;

  assign res  = f32_to_u32(fin, rm);
  assign uout = res.val;
  assign inv  = res.inv;
  assign inx  = res.inx;

  always_comb begin
    if (inv) begin
      a_inv_sat_r2: assert (uout == {EW{1'b1}});
      a_inv_no_inx_r3: assert (!inx);
    end
  end
endmodule

// File: rtl/pcvt_lane_route.sv
module pcvt_lane_route
  import pcvt_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] own_lane,
  input  logic [EW-1:0] lane0,
  input  logic [EW-1:0] old_lane,
  input  logic          mbit,
  input  logic          mask_en,
  input  logic          zero_mode,
  input  logic          bcast_eff,
  input  logic          in_range,
  input  rmode_e        rm,
  output logic [EW-1:0] lane_out,
  output logic          lane_inv,
  output logic          lane_inx,
  output logic          active
);
  logic [EW-1:0] operand;
  logic [EW-1:0] conv;
  logic          c_inv;
  logic          c_inx;

  assign active  = in_range & (mbit | ~mask_en);
  assign operand = bcast_eff ? lane0 : own_lane;

  pcvt_cvt_lane #(.EW(EW)) u_cvt (
    .fin  (operand),
    .rm   (rm),
    .uout (conv),
    .inv  (c_inv),
    .inx  (c_inx)
  );

  always_comb begin
    if (!in_range)      lane_out = '0;
    else if (active)    lane_out = conv;
    else if (zero_mode) lane_out = '0;
    else                lane_out = old_lane;
  end

  assign lane_inv = active & c_inv;
  assign lane_inx = active & c_inx;

  // R9: an inactive lane raises no flag
  always_comb begin
    if (!active) begin
      a_quiet_lane_r9: assert (!lane_inv && !lane_inx);
    end
  end
endmodule

// File: rtl/pcvt_unit.sv
module pcvt_unit
  import pcvt_pkg::*;
#(
  parameter int LANES_MAX = 16,
  parameter int EW        = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [LANES_MAX*EW-1:0]     src,
  input  logic [LANES_MAX*EW-1:0]     old_dst,
  input  logic [LANES_MAX-1:0]        mask,
  input  logic                        mask_en,
  input  logic                        zero_mode,
  input  logic                        bcast,
  input  logic                        mem_src,
  input  logic [1:0]                  vlen,
  input  logic [1:0]                  emb_rc,
  input  logic [1:0]                  glb_rc,
  input  logic                        emb_rnd_en,
  output logic                        out_valid,
  output logic [LANES_MAX*EW-1:0]     result,
  output logic                        flag_invalid,
  output logic                        flag_precision
);
  localparam int VW = LANES_MAX * EW;

  rmode_e               rm;
  logic                 emb_taken;
  logic                 bcast_eff;
  int unsigned          nlanes;
  logic [LANES_MAX-1:0] in_rng;
  logic [LANES_MAX-1:0] lane_inv;
  logic [LANES_MAX-1:0] lane_inx;
  logic [LANES_MAX-1:0] lane_act;
  logic [VW-1:0]        next_res;

  assign nlanes    = lanes_for(vlen);
  assign bcast_eff = mem_src & bcast;

  pcvt_rnd_sel u_rsel (
    .vlen       (vlen),
    .emb_rnd_en (emb_rnd_en),
    .mem_src    (mem_src),
    .emb_rc     (emb_rc),
    .glb_rc     (glb_rc),
    .rm         (rm),
    .emb_taken  (emb_taken)
  );

  for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
    assign in_rng[j] = (32'(j) < nlanes);
    pcvt_lane_route #(.EW(EW)) u_route (
      .own_lane  (src[j*EW +: EW]),
      .lane0     (src[EW-1:0]),
      .old_lane  (old_dst[j*EW +: EW]),
      .mbit      (mask[j]),
      .mask_en   (mask_en),
      .zero_mode (zero_mode),
      .bcast_eff (bcast_eff),
      .in_range  (in_rng[j]),
      .rm        (rm),
      .lane_out  (next_res[j*EW +: EW]),
      .lane_inv  (lane_inv[j]),
      .lane_inx  (lane_inx[j]),
      .active    (lane_act[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      flag_invalid   <= 1'b0;
      flag_precision <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result         <= next_res;
        flag_invalid   <= |lane_inv;
        flag_precision <= |lane_inx;
      end
    end
  end

  // Active lanes never exceed the selected length (R6)
  always_comb begin
    a_act_in_len_r6: assert ((lane_act & ~in_rng) == '0);
  end

  p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vlen == 2'b00) |=> (result[VW-1:4*EW] == '0));

  p_merge_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && !zero_mode && mask == '0 && vlen[1])
      |=> (result == $past(old_dst)));

  p_zero_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && zero_mode && mask == '0)
      |=> (result == '0 && !flag_invalid && !flag_precision));
endmodule

// File: tb/pcvt_unit_test.sv
`timescale 1ns/1ps
module pcvt_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0;
  logic [511:0] old_dst = '0;
  logic [15:0]  mask = '0;
  logic         mask_en = 1'b0;
  logic         zero_mode = 1'b0;
  logic         bcast = 1'b0;
  logic         mem_src = 1'b0;
  logic [1:0]   vlen = 2'b10;
  logic [1:0]   emb_rc = 2'b00;
  logic [1:0]   glb_rc = 2'b00;
  logic         emb_rnd_en = 1'b0;
  logic         out_valid;
  logic [511:0] result;
  logic         flag_invalid;
  logic         flag_precision;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pcvt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .mem_src(mem_src), .vlen(vlen), .emb_rc(emb_rc), .glb_rc(glb_rc),
    .emb_rnd_en(emb_rnd_en), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_precision(flag_precision)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic real pow2(input int n);
    real p = 1.0;
    if (n >= 0) for (int k = 0; k < n; k++) p = p * 2.0;
    else for (int k = 0; k < -n; k++) p = p / 2.0;
    return p;
  endfunction

  // Real-valued model of one lane conversion
  task automatic model_lane(input logic [31:0] f, input logic [1:0] rm,
                            output logic [31:0] v, output logic inv, output logic inx);
    real x, fl, d, r;
    int e;
    e = int'(f[30:23]);
    inv = 1'b0; inx = 1'b0; v = 32'd0;
    if (e == 255) begin
      inv = 1'b1; v = 32'hFFFF_FFFF;
    end else begin
      if (e == 0) x = real'(f[22:0]) * pow2(-149);
      else x = (real'(f[22:0]) + 8388608.0) * pow2(e - 150);
      if (f[31]) x = -x;
      fl = $floor(x);
      d = x - fl;
      if (d == 0.0) r = x;
      else case (rm)
        2'b00: begin
          if (d > 0.5) r = fl + 1.0;
          else if (d < 0.5) r = fl;
          else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
        end
        2'b01: r = fl;
        2'b10: r = fl + 1.0;
        default: r = (x < 0.0) ? fl + 1.0 : fl;
      endcase
      if (r < 0.0 || r > 4294967295.0) begin
        inv = 1'b1; v = 32'hFFFF_FFFF;
      end else begin
        v = 32'(longint'(r));
        inx = (d != 0.0);
      end
    end
  endtask

  task automatic model_vec(output logic [511:0] ev, output logic ei, output logic ep);
    int n;
    logic [1:0] rm;
    logic [31:0] op, v;
    logic li, lx, act;
    n = (vlen == 2'b00) ? 4 : (vlen == 2'b01) ? 8 : 16;
    rm = (n == 16 && emb_rnd_en && !mem_src) ? emb_rc : glb_rc;
    ev = '0; ei = 1'b0; ep = 1'b0;
    for (int j = 0; j < 16; j++) begin
      if (j < n) begin
        act = mask[j] || !mask_en;
        op = (mem_src && bcast) ? src[31:0] : src[j*32 +: 32];
        if (act) begin
          model_lane(op, rm, v, li, lx);
          ev[j*32 +: 32] = v;
          ei = ei | li;
          ep = ep | lx;
        end else begin
          ev[j*32 +: 32] = zero_mode ? 32'd0 : old_dst[j*32 +: 32];
        end
      end
    end
  endtask

  task automatic check(input string req, input string what, input logic [511:0] act,
                       input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply the current inputs, then compare one cycle later
  task automatic apply(input string req);
    logic [511:0] ev;
    logic ei, ep;
    model_vec(ev, ei, ep);
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "valid", {511'd0, out_valid}, 512'd1);
    check(req, "result", result, ev);
    check(req, "invalid", {511'd0, flag_invalid}, {511'd0, ei});
    check(req, "precision", {511'd0, flag_precision}, {511'd0, ep});
  endtask

  task automatic set_defaults();
    mask = '0; mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0; mem_src = 1'b0;
    vlen = 2'b10; emb_rc = 2'b00; glb_rc = 2'b00; emb_rnd_en = 1'b0;
  endtask

  logic [31:0] edge_vals [32] = '{
    32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'h3FC0_0000,
    32'h4020_0000, 32'h3F00_0000, 32'hBF00_0000, 32'hBF80_0000,
    32'h406C_CCCD, 32'h4F7F_FFFF, 32'h4F80_0000, 32'h7F80_0000,
    32'hFF80_0000, 32'h7FC0_0000, 32'h0000_0001, 32'h8000_0001,
    32'h3EFF_FFFF, 32'h4AFF_FFFF, 32'h4B7F_FFFF, 32'h4E80_0000,
    32'hBE99_999A, 32'h3F40_0000, 32'h4060_0000, 32'hC020_0000,
    32'h4B00_0001, 32'h4F7F_FFFE, 32'h5F00_0000, 32'hFFC0_0001,
    32'h3F7F_FFFF, 32'h4EFF_FFFF, 32'h4040_0000, 32'hBEFF_FFFF
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset valid", {511'd0, out_valid}, 512'd0);
    check("R10", "reset result", result, 512'd0);
    check("R10", "reset flags", {510'd0, flag_invalid, flag_precision}, 512'd0);
    rst_n = 1'b1;

    // R1 R2 R3: boundary encodings and random lanes under all four modes
    for (int m = 0; m < 4; m++) begin
      set_defaults();
      glb_rc = 2'(m);
      for (int g = 0; g < 2; g++) begin
        for (int j = 0; j < 16; j++) src[j*32 +: 32] = edge_vals[g*16 + j];
        apply("R1");
      end
      for (int k = 0; k < 32; k++) begin
        for (int j = 0; j < 16; j++) begin
          logic [31:0] w;
          w = rnd();
          // Steer exponents toward the convertible range
          if (k[0]) w[30:23] = 8'd120 + 8'(w[3:0]) + 8'(w[7:4] & 4'h3) * 8'd10;
          src[j*32 +: 32] = w;
        end
        apply("R2");
      end
    end

    // Single-lane flag isolation: one invalid or inexact lane, then masked off
    set_defaults();
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = 32'h4000_0000;
    src[7*32 +: 32] = 32'h7FC0_0000;
    src[9*32 +: 32] = 32'h3FC0_0000;
    apply("R3");
    mask_en = 1'b1; mask = 16'hFFFF; mask[7] = 1'b0; mask[9] = 1'b0;
    for (int z = 0; z < 2; z++) begin
      zero_mode = z[0];
      old_dst = {16{rnd()}};
      apply("R9");
    end

    // R4 R5 R9: mask patterns, merge and zero
    for (int z = 0; z < 2; z++) begin
      for (int p = 0; p < 24; p++) begin
        set_defaults();
        zero_mode = z[0];
        mask_en = 1'b1;
        mask = (p < 16) ? (16'd1 << p) : rnd()[15:0];
        if (p == 16) mask = 16'h0000;
        for (int j = 0; j < 16; j++) begin
          src[j*32 +: 32] = edge_vals[(j + p) % 32];
          old_dst[j*32 +: 32] = rnd();
        end
        apply("R5");
      end
    end
    set_defaults();
    mask = 16'h0000; mask_en = 1'b0;
    apply("R4");

    // R6: all length codes with random masks and merge data
    for (int l = 0; l < 4; l++) begin
      for (int k = 0; k < 3; k++) begin
        set_defaults();
        vlen = 2'(l);
        mask_en = k[0]; mask = rnd()[15:0]; zero_mode = k[1];
        for (int j = 0; j < 16; j++) begin
          src[j*32 +: 32] = edge_vals[(j * 3 + k) % 32];
          old_dst[j*32 +: 32] = rnd();
        end
        apply("R6");
      end
    end

    // R7: embedded versus global rounding code
    for (int c = 0; c < 8; c++) begin
      set_defaults();
      for (int j = 0; j < 16; j++) src[j*32 +: 32] = edge_vals[j + 2];
      emb_rnd_en = 1'b1; emb_rc = 2'b10; glb_rc = 2'b11;
      vlen = (c[1:0] == 2'b00) ? 2'b01 : (c[1:0] == 2'b01) ? 2'b00 : 2'(c[1:0]);
      mem_src = c[2];
      apply("R7");
    end
    set_defaults();
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = edge_vals[j + 2];
    emb_rnd_en = 1'b0; emb_rc = 2'b10; glb_rc = 2'b01;
    apply("R7");

    // R8: broadcast from a memory-style source, ignored for a register source
    for (int b = 0; b < 6; b++) begin
      set_defaults();
      bcast = 1'b1; mem_src = (b != 5); glb_rc = 2'(b);
      mask_en = b[0]; mask = 16'hA5C3; vlen = (b == 3) ? 2'b01 : 2'b10;
      for (int j = 0; j < 16; j++) src[j*32 +: 32] = edge_vals[(j + b * 5) % 32];
      src[31:0] = edge_vals[b + 2];
      apply("R8");
    end

    // R10: hold without a request
    begin
      logic [511:0] held;
      held = result;
      @(negedge clk);
      src = ~src; mask = ~mask; old_dst = {16{rnd()}};
      repeat (3) @(negedge clk);
      check("R10", "idle valid", {511'd0, out_valid}, 512'd0);
      check("R10", "idle hold", result, held);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule